// File: doc/BRIEF.md
# Segmented DAC Digital Front End

This block is the digital input path of a 10-bit current-steering converter. Each rising clock edge it captures a parallel code and a fold control. When folding is requested and the top bit of the code is clear, it inverts the nine lower bits. Folding a rising phase ramp this way gives the mirrored half of a quadrature waveform with no external logic.

The word is then split into two segments. The upper four bits are decoded into fifteen unit-weight thermometer lines. The lower six bits stay binary and take the same number of register stages, so both segments reach the switch drivers in the same cycle. The output stage drives a true enable vector and a separately registered complementary vector for each segment. The enabled weights on the two sides always add up to full scale minus one LSB.

Top module: `dac_seg_frontend`

## Requirements
- R1: The code is 10 bits, with `code_in[9]` as the MSB and `code_in[0]` as the LSB. It is captured only on a rising edge. The word captured at one edge appears on the enable outputs after the second rising edge that follows, so it is visible three rising edges after it was presented.
- R2: With `fold_en` low, the captured word reaches the outputs unchanged.
- R3: With `fold_en` high and `code_in[9]` low, bits 8..0 are inverted before decoding.
- R4: The MSB is never altered. With `fold_en` high and `code_in[9]` high, the word passes unchanged.
- R5: `fold_en` is captured at the same edge as the code, so each word is folded according to its own control value, even when the control changes every cycle.
- R6: Bits 9..6 of the processed word, value k, drive `therm_on`. Line i (0..14) is set exactly when k > i, so k lines are set, starting from line 0.
- R7: Bits 5..0 of the processed word appear on `bin_on` (bit 5 = weight 32) in the same cycle as the thermometer lines that belong to that word.
- R8: `therm_off` and `bin_off` are always the bitwise complements of `therm_on` and `bin_on`. The weighted on-side sum (64 per line plus the binary value) equals the processed word.
- R9: An all-ones processed word sets every true-side enable and clears every complementary enable.
- R10: A synchronous active-high `rst` clears every stage. From the edge that samples it, the outputs show the zero code (all on-enables low, all off-enables high), and no word that was in flight emerges afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 10 | Parallel input code, bit 9 is the MSB |
| fold_en | input | 1 | Fold control: inverts bits 8..0 when bit 9 is low |
| therm_on | output | 15 | True-side thermometer enables for the upper segment |
| therm_off | output | 15 | Complementary thermometer enables |
| bin_on | output | 6 | True-side binary enables for the lower segment |
| bin_off | output | 6 | Complementary binary enables |

## Verification
Every result is due exactly three rising edges after its code and fold control are presented: one edge for capture, one for the segment register and one for the driver register. The bench drives inputs on falling edges and keeps a history of presented words. At each falling edge it compares the outputs with the entry from three falling edges earlier, so both segments are checked in the same cycle. A reset asserted mid-run clears the two in-flight history entries, and the bench expects zeros for the following three cycles.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int CODE_W  = 10;
    localparam int HI_W    = 4;
    localparam int LO_W    = CODE_W - HI_W;
    localparam int THERM_W = (1 << HI_W) - 1;
    localparam int UNIT_W  = 1 << LO_W;

    typedef struct packed {
        logic              fold;
        logic [CODE_W-1:0] code;
    } cap_t;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } seg_t;

    typedef struct packed {
        logic [THERM_W-1:0] therm_on;
        logic [THERM_W-1:0] therm_off;
        logic [LO_W-1:0]    bin_on;
        logic [LO_W-1:0]    bin_off;
    } drv_t;

    function automatic logic [CODE_W-1:0] fold_ref(input logic [CODE_W-1:0] c, input logic f);
        logic [CODE_W-1:0] r;
        r = c;
        if (f && !c[CODE_W-1]) r[CODE_W-2:0] = ~c[CODE_W-2:0];
        return r;
    endfunction
endpackage

// File: rtl/dacfe_capture.sv
module dacfe_capture import dacfe_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              fold,
    output cap_t              cap_q
);
    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else begin
            cap_q.code <= code;
            cap_q.fold <= fold;
        end
    end
endmodule

// File: rtl/dacfe_fold.sv
module dacfe_fold import dacfe_pkg::*; (
    input  cap_t              cap,
    output logic [CODE_W-1:0] word
);
    logic flip;
    assign flip = cap.fold & ~cap.code[CODE_W-1];
    assign word[CODE_W-1] = cap.code[CODE_W-1];
    for (genvar i = 0; i < CODE_W - 1; i++) begin : g_bit
        assign word[i] = cap.code[i] ^ flip;
    end
endmodule

// File: rtl/dacfe_therm_dec.sv
module dacfe_therm_dec import dacfe_pkg::*; (
    input  logic [HI_W-1:0]    hi,
    output logic [THERM_W-1:0] therm
);
    for (genvar i = 0; i < THERM_W; i++) begin : g_line
        assign therm[i] = (hi > HI_W'(i));
    end
endmodule

// File: rtl/dacfe_driver.sv
module dacfe_driver import dacfe_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic [THERM_W-1:0] therm,
    input  logic [LO_W-1:0]    lo,
    output drv_t               drv_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q.therm_on  <= '0;
            drv_q.therm_off <= '1;
            drv_q.bin_on    <= '0;
            drv_q.bin_off   <= '1;
        end else begin
            drv_q.therm_on  <= therm;
            drv_q.therm_off <= ~therm;
            drv_q.bin_on    <= lo;
            drv_q.bin_off   <= ~lo;
        end
    end
endmodule

// File: rtl/dac_seg_frontend.sv
module dac_seg_frontend import dacfe_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic [CODE_W-1:0]  code_in,
    input  logic               fold_en,
    output logic [THERM_W-1:0] therm_on,
    output logic [THERM_W-1:0] therm_off,
    output logic [LO_W-1:0]    bin_on,
    output logic [LO_W-1:0]    bin_off
);
    cap_t               cap_q;
    logic [CODE_W-1:0]  folded;
    seg_t               seg_q;
    logic [THERM_W-1:0] therm_d;
    drv_t               drv_q;

    dacfe_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .code  (code_in),
        .fold  (fold_en),
        .cap_q (cap_q)
    );

    dacfe_fold u_fold (
        .cap  (cap_q),
        .word (folded)
    );

    // segment register: both fields take this stage, so they stay aligned
    always_ff @(posedge clk) begin
        if (rst) seg_q <= '0;
        else begin
            seg_q.hi <= folded[CODE_W-1 -: HI_W];
            seg_q.lo <= folded[LO_W-1:0];
        end
    end

    dacfe_therm_dec u_dec (
        .hi    (seg_q.hi),
        .therm (therm_d)
    );

    dacfe_driver u_drv (
        .clk   (clk),
        .rst   (rst),
        .therm (therm_d),
        .lo    (seg_q.lo),
        .drv_q (drv_q)
    );

    assign therm_on  = drv_q.therm_on;
    assign therm_off = drv_q.therm_off;
    assign bin_on    = drv_q.bin_on;
    assign bin_off   = drv_q.bin_off;
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker import dacfe_pkg::*; (
    input logic               clk,
    input logic               rst,
    input logic [CODE_W-1:0]  code_in,
    input logic               fold_en,
    input logic [THERM_W-1:0] therm_on,
    input logic [THERM_W-1:0] therm_off,
    input logic [LO_W-1:0]    bin_on,
    input logic [LO_W-1:0]    bin_off
);
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    function automatic logic [CODE_W-1:0] weight(input logic [THERM_W-1:0] t, input logic [LO_W-1:0] b);
        return CODE_W'($countones(t)) * CODE_W'(UNIT_W) + CODE_W'(b);
    endfunction

    // R1 R8: on-side weight equals the processed word from three edges back
    p_weight_r1: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (weight(therm_on, bin_on) ==
                            fold_ref($past(code_in, 3), $past(fold_en, 3))));

    p_msb_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (therm_on[THERM_W/2] == $past(code_in[CODE_W-1], 3)));

    p_therm_shape_r6: assert property (@(posedge clk) disable iff (rst)
        ((therm_on & (therm_on + THERM_W'(1))) == '0));

    p_complement_r8: assert property (@(posedge clk) disable iff (rst)
        (therm_off == ~therm_on) && (bin_off == ~bin_on));

    p_reset_zero_r10: assert property (@(posedge clk)
        rst |=> (therm_on == '0) && (bin_on == '0) && (&therm_off) && (&bin_off));
endmodule

bind dac_seg_frontend dacfe_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .code_in   (code_in),
    .fold_en   (fold_en),
    .therm_on  (therm_on),
    .therm_off (therm_off),
    .bin_on    (bin_on),
    .bin_off   (bin_off)
);

// File: tb/dac_seg_frontend_tb.sv
module dac_seg_frontend_tb;
    localparam int NCYC   = 1500;
    localparam int RST_AT = 700;
    localparam int NDIR   = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] code_in = '0;
    logic       fold_en = 1'b0;
    logic [14:0] therm_on, therm_off;
    logic [5:0]  bin_on, bin_off;

    int checks = 0;
    int errors = 0;

    logic [9:0] h_code [0:NCYC-1];
    logic       h_fold [0:NCYC-1];
    logic       h_rst  [0:NCYC-1];

    always #5 clk = ~clk;

    dac_seg_frontend u_dut (
        .clk(clk), .rst(rst), .code_in(code_in), .fold_en(fold_en),
        .therm_on(therm_on), .therm_off(therm_off),
        .bin_on(bin_on), .bin_off(bin_off)
    );

    function automatic logic [9:0] exp_word(input logic [9:0] c, input logic f);
        if (f && (c[9] == 1'b0)) return {1'b0, ~c[8:0]};
        return c;
    endfunction

    function automatic logic [14:0] exp_therm(input logic [3:0] k);
        logic [14:0] t;
        for (int i = 0; i < 15; i++) t[i] = (i < int'(k));
        return t;
    endfunction

    function automatic logic [10:0] dir_vec(input int k);
        case (k)
            0: return {1'b0, 10'h3FF};
            1: return {1'b0, 10'h000};
            2: return {1'b1, 10'h3FF};
            3: return {1'b1, 10'h1FF};
            4: return {1'b1, 10'h000};
            5: return {1'b1, 10'h200};
            6: return {1'b0, 10'h1C0};
            7: return {1'b1, 10'h1C0};
            8: return {1'b1, 10'h155};
            default: return {1'b1, 10'h2AA};
        endcase
    endfunction

    task automatic check(input int idx);
        logic [9:0] w;
        string cls;
        w = h_rst[idx] ? 10'h000 : exp_word(h_code[idx], h_fold[idx]);
        if (h_rst[idx]) cls = "R10";
        else if (!h_fold[idx]) cls = "R2";
        else if (!h_code[idx][9]) cls = "R3/R5";
        else cls = "R4/R5";
        // R1: sampled exactly three rising edges after presentation
        checks++;
        if (therm_on !== exp_therm(w[9:6])) begin
            errors++;
            $display("FAIL R6 R1 %s: therm_on=%h expected %h", cls, therm_on, exp_therm(w[9:6]));
        end
        checks++;
        if (bin_on !== w[5:0]) begin
            errors++;
            $display("FAIL R7 R1 %s: bin_on=%h expected %h", cls, bin_on, w[5:0]);
        end
        checks++;
        if (therm_off !== ~exp_therm(w[9:6]) || bin_off !== ~w[5:0]) begin
            errors++;
            $display("FAIL R8 %s: off=%h/%h expected %h/%h", cls, therm_off, bin_off,
                     ~exp_therm(w[9:6]), ~w[5:0]);
        end
        if (w == 10'h3FF) begin
            checks++;
            if (therm_on !== 15'h7FFF || bin_on !== 6'h3F || therm_off !== '0 || bin_off !== '0) begin
                errors++;
                $display("FAIL R9: on=%h/%h off=%h/%h expected 7fff/3f 0/0",
                         therm_on, bin_on, therm_off, bin_off);
            end
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [10:0] v;
        void'($urandom(32'd2024));
        for (int n = 0; n < NCYC; n++) begin
            @(negedge clk);
            if (n >= 3) check(n - 3);
            v = {1'($urandom()), 10'($urandom())};
            if (n < 4) begin
                rst = 1'b1;
            end else if (n == RST_AT) begin
                rst = 1'b1;
                h_rst[n-1] = 1'b1;
                h_rst[n-2] = 1'b1;
            end else begin
                rst = 1'b0;
                if (n - 4 < NDIR) v = dir_vec(n - 4);
            end
            fold_en  = v[10];
            code_in  = v[9:0];
            h_code[n] = v[9:0];
            h_fold[n] = v[10];
            h_rst[n]  = rst;
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule